// File: doc/BRIEF.md
# Ethernet Channel Event and Interrupt Register

This block collects single-cycle event pulses from an Ethernet channel's transmit and receive datapaths. Each pulse sets a sticky bit in a 16-bit event register. A companion mask register selects which of those bits may raise the channel's level-sensitive interrupt request. Software reads either register through a small strobe-based port. It clears event bits by writing ones to them.

The block also follows a graceful-stop-transmit command. When the command arrives while a frame is on the wire, the stop-complete event waits for that frame to end. When the transmitter is idle, the event is raised at once. From the command onward, a transmit-enable output blocks the start of new frames until a restart input re-enables transmission.

The datapath and the register port carry no data streams, so every pin is plain control or status. There is no valid/ready handshake and no back-pressure: event pulses are always accepted in the cycle they appear.

Top module: `eth_evt_irq`

## Requirements
- R1: Event bit positions, counted from bit 0, are: 0 receive-buffer, 1 buffer-transmitted, 2 busy (frame discarded for lack of buffers), 3 frame-received, 4 transmit error, 7 graceful-stop-complete. A pulse on an event input sets its bit, and the bit is visible on the read port after the next rising clock edge.
- R2: Writing the event register (`reg_sel_i`=0) clears every bit written as 1 and leaves every bit written as 0 unchanged. One write may clear several bits.
- R3: After reset, the event register and the mask register both read 0, `irq_o` is low and `tx_en_o` is high.
- R4: A set event bit stays set until software clears it.
- R5: `irq_o` is high whenever any event bit is set and its mask bit (`reg_sel_i`=1) is 1. It falls only after every such bit has been cleared or masked off by a register write.
- R6: The mask register uses the same bit layout as the event register, reads back what was written, and a 1 enables the matching event.
- R7: Reserved bits (5, 6, 8 to 15) read as 0 in both registers. Writes to them have no effect.
- R8: If an event pulse and a write-one-to-clear of the same bit occur in the same cycle, the bit ends up set.
- R9: A graceful-stop command that arrives while no frame is in progress (`tx_active_i` low, or the frame ends in that same cycle) sets bit 7 after the next edge.
- R10: A graceful-stop command that arrives during a frame sets bit 7 only in the cycle after `tx_frame_end_i` pulses.
- R11: `tx_en_o` falls after the edge that takes a graceful-stop command. It rises again only after a `restart_i` pulse arrives once no stop is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rxb_i | input | 1 | Receive buffer closed pulse |
| ev_txb_i | input | 1 | Buffer transmitted pulse |
| ev_bsy_i | input | 1 | Frame discarded for lack of buffers pulse |
| ev_rxf_i | input | 1 | Complete frame received pulse |
| ev_txe_i | input | 1 | Transmit error pulse |
| tx_active_i | input | 1 | A frame is being transmitted |
| tx_frame_end_i | input | 1 | Pulse on the last cycle of a transmitted frame |
| gstop_cmd_i | input | 1 | Graceful-stop-transmit command pulse |
| restart_i | input | 1 | Restart-transmit command pulse |
| tx_en_o | output | 1 | New frames may start when high |
| reg_sel_i | input | 1 | Register select: 0 event, 1 mask |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data of the selected register |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions assume the following about the inputs:
- `tx_frame_end_i` pulses only while `tx_active_i` is high.
- Event and command inputs are single-cycle pulses that are low during reset.
- The irq-fall property assumes that only register writes can remove a pending unmasked event.

The stimulus drives every pulse for exactly one cycle between falling edges. It raises `tx_frame_end_i` only inside a frame it has opened with `tx_active_i`. It never holds a register write across more than one edge.

// File: rtl/eth_evt_pkg.sv
package eth_evt_pkg;
  localparam int EVT_W = 16;
  localparam int B_RXB = 0;
  localparam int B_TXB = 1;
  localparam int B_BSY = 2;
  localparam int B_RXF = 3;
  localparam int B_TXE = 4;
  localparam int B_GSC = 7;
  localparam logic [EVT_W-1:0] EVT_VALID =
    (EVT_W'(1) << B_RXB) | (EVT_W'(1) << B_TXB) | (EVT_W'(1) << B_BSY) |
    (EVT_W'(1) << B_RXF) | (EVT_W'(1) << B_TXE) | (EVT_W'(1) << B_GSC);
  typedef enum logic {SEL_EVT = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/eth_evt_sticky.sv
module eth_evt_sticky #(
  parameter int W = 16,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic b_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        b_q <= 1'b0;
        else if (set_i[i]) b_q <= 1'b1;
        else if (clr_i[i]) b_q <= 1'b0;
      end
      assign q_o[i] = b_q;
    end else begin : g_rsvd
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/eth_gstop_ctl.sv
module eth_gstop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic gstop_cmd_i,
  input  logic restart_i,
  input  logic tx_active_i,
  input  logic tx_frame_end_i,
  output logic gsc_set_o,
  output logic pending_o,
  output logic tx_en_o
);
  logic pending_q, halted_q, in_frame, now_done;

  assign in_frame = tx_active_i && !tx_frame_end_i;
  assign now_done = gstop_cmd_i && !in_frame && !pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      halted_q  <= 1'b0;
    end else begin
      if (pending_q && tx_frame_end_i)  pending_q <= 1'b0;
      else if (gstop_cmd_i && in_frame) pending_q <= 1'b1;
      if (gstop_cmd_i)                  halted_q <= 1'b1;
      else if (restart_i && !pending_q) halted_q <= 1'b0;
    end
  end

  assign gsc_set_o = now_done || (pending_q && tx_frame_end_i);
  assign pending_o = pending_q;
  assign tx_en_o   = !halted_q;
endmodule

// File: rtl/eth_evt_irq.sv
module eth_evt_irq
  import eth_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rxb_i,
  input  logic             ev_txb_i,
  input  logic             ev_bsy_i,
  input  logic             ev_rxf_i,
  input  logic             ev_txe_i,
  input  logic             tx_active_i,
  input  logic             tx_frame_end_i,
  input  logic             gstop_cmd_i,
  input  logic             restart_i,
  output logic             tx_en_o,
  input  logic             reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [EVT_W-1:0] reg_wdata_i,
  output logic [EVT_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] set_vec, clr_vec, evt_q, mask_q;
  logic             gsc_set, pending;

  eth_gstop_ctl u_gstop (
    .clk(clk), .rst_n(rst_n), .gstop_cmd_i(gstop_cmd_i), .restart_i(restart_i),
    .tx_active_i(tx_active_i), .tx_frame_end_i(tx_frame_end_i),
    .gsc_set_o(gsc_set), .pending_o(pending), .tx_en_o(tx_en_o)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[B_RXB] = ev_rxb_i;
    set_vec[B_TXB] = ev_txb_i;
    set_vec[B_BSY] = ev_bsy_i;
    set_vec[B_RXF] = ev_rxf_i;
    set_vec[B_TXE] = ev_txe_i;
    set_vec[B_GSC] = gsc_set;
  end

  assign clr_vec = (reg_wr_i && reg_sel_i == SEL_EVT) ? reg_wdata_i : '0;

  eth_evt_sticky #(.W(EVT_W), .VALID(EVT_VALID)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(evt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (reg_wr_i && reg_sel_i == SEL_MASK) mask_q <= reg_wdata_i & EVT_VALID;
  end

  assign reg_rdata_o = (reg_sel_i == SEL_MASK) ? mask_q : evt_q;
  assign irq_o       = |(evt_q & mask_q);
endmodule

// File: rtl/eth_evt_irq_chk.sv
module eth_evt_irq_chk
  import eth_evt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ev_txe_i,
  input logic             ev_rxb_i,
  input logic             gstop_cmd_i,
  input logic             tx_active_i,
  input logic             tx_frame_end_i,
  input logic             pending,
  input logic             tx_en_o,
  input logic             reg_sel_i,
  input logic             reg_wr_i,
  input logic [EVT_W-1:0] reg_wdata_i,
  input logic [EVT_W-1:0] reg_rdata_o,
  input logic [EVT_W-1:0] evt_q,
  input logic             irq_o
);
  logic evt_wr;
  assign evt_wr = reg_wr_i && !reg_sel_i;

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  // R1
  txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txe_i |=> evt_q[B_TXE]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rxb_i && evt_wr && reg_wdata_i[B_RXB]) |=> evt_q[B_RXB]);
  // R5
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(reg_wr_i));
  // R9
  gsc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gstop_cmd_i && !tx_active_i) |=> evt_q[B_GSC]);
  // R10
  gsc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && tx_frame_end_i) |=> evt_q[B_GSC]);
  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gstop_cmd_i |=> !tx_en_o);
  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & ~EVT_VALID) == '0);
endmodule

bind eth_evt_irq eth_evt_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_txe_i(ev_txe_i), .ev_rxb_i(ev_rxb_i),
  .gstop_cmd_i(gstop_cmd_i), .tx_active_i(tx_active_i),
  .tx_frame_end_i(tx_frame_end_i), .pending(pending), .tx_en_o(tx_en_o),
  .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .evt_q(evt_q), .irq_o(irq_o)
);

// File: tb/eth_evt_irq_tb.sv
module eth_evt_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rxb = 0, ev_txb = 0, ev_bsy = 0, ev_rxf = 0, ev_txe = 0;
  logic tx_act = 0, tx_end = 0, gcmd = 0, rstrt = 0;
  logic sel = 0, wr = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, tx_en;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  eth_evt_irq dut_i (
    .clk(clk), .rst_n(rst_n), .ev_rxb_i(ev_rxb), .ev_txb_i(ev_txb),
    .ev_bsy_i(ev_bsy), .ev_rxf_i(ev_rxf), .ev_txe_i(ev_txe),
    .tx_active_i(tx_act), .tx_frame_end_i(tx_end), .gstop_cmd_i(gcmd),
    .restart_i(rstrt), .tx_en_o(tx_en), .reg_sel_i(sel), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [15:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic wr_reg(input logic s, input logic [15:0] d);
    sel = s; wr = 1; wdata = d;
    @(negedge clk); wr = 0; wdata = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, v); check("R3 evt", v, 16'h0);
    rd(1, v); check("R3 mask", v, 16'h0);
    check("R3 irq", {15'b0, irq}, 16'h0);
    check("R3 tx_en", {15'b0, tx_en}, 16'h1);
  endtask

  task automatic t_set_sticky();
    logic [15:0] v;
    ev_rxb = 1; @(negedge clk); ev_rxb = 0; rd(0, v); check("R1 rxb", v, 16'h0001);
    ev_txb = 1; @(negedge clk); ev_txb = 0; rd(0, v); check("R1 txb", v, 16'h0003);
    ev_bsy = 1; ev_rxf = 1; @(negedge clk); ev_bsy = 0; ev_rxf = 0;
    rd(0, v); check("R1 bsy rxf", v, 16'h000F);
    ev_txe = 1; @(negedge clk); ev_txe = 0; rd(0, v); check("R1 txe", v, 16'h001F);
    repeat (5) @(negedge clk);
    rd(0, v); check("R4 hold", v, 16'h001F);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    wr_reg(0, 16'h0000); rd(0, v); check("R2 zero write", v, 16'h001F);
    wr_reg(0, 16'h0005); rd(0, v); check("R2 multi clear", v, 16'h001A);
    wr_reg(0, 16'hFFFF); rd(0, v); check("R2 clear all", v, 16'h0000);
  endtask

  task automatic t_mask_irq();
    logic [15:0] v;
    wr_reg(1, 16'h0010); rd(1, v); check("R6 mask rb", v, 16'h0010);
    ev_rxf = 1; @(negedge clk); ev_rxf = 0;
    check("R6 masked off no irq", {15'b0, irq}, 16'h0);
    ev_txe = 1; @(negedge clk); ev_txe = 0;
    check("R5 irq on", {15'b0, irq}, 16'h1);
    wr_reg(0, 16'h0008); check("R5 irq stays", {15'b0, irq}, 16'h1);
    wr_reg(0, 16'h0010); check("R5 irq off", {15'b0, irq}, 16'h0);
    wr_reg(1, 16'h0000);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    wr_reg(1, 16'hFFFF); rd(1, v); check("R7 mask rsvd", v, 16'h009F);
    wr_reg(1, 16'h0000);
    wr_reg(0, 16'hFF60); rd(0, v); check("R7 evt rsvd", v, 16'h0000);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    ev_rxb = 1; sel = 0; wr = 1; wdata = 16'h0001;
    @(negedge clk); ev_rxb = 0; wr = 0; wdata = '0;
    rd(0, v); check("R8 set wins", v, 16'h0001);
    wr_reg(0, 16'h0001);
  endtask

  task automatic t_gstop_idle();
    logic [15:0] v;
    gcmd = 1; @(negedge clk); gcmd = 0;
    rd(0, v); check("R9 gsc immediate", v, 16'h0080);
    check("R11 tx_en low", {15'b0, tx_en}, 16'h0);
    rstrt = 1; @(negedge clk); rstrt = 0;
    check("R11 restart", {15'b0, tx_en}, 16'h1);
    wr_reg(0, 16'h0080);
  endtask

  task automatic t_gstop_busy();
    logic [15:0] v;
    tx_act = 1; @(negedge clk);
    gcmd = 1; @(negedge clk); gcmd = 0;
    rd(0, v); check("R10 not yet", v, 16'h0000);
    check("R11 tx_en low busy", {15'b0, tx_en}, 16'h0);
    rstrt = 1; @(negedge clk); rstrt = 0;
    check("R11 restart while pending", {15'b0, tx_en}, 16'h0);
    repeat (3) @(negedge clk);
    rd(0, v); check("R10 still waiting", v, 16'h0000);
    tx_end = 1; @(negedge clk); tx_end = 0; tx_act = 0;
    rd(0, v); check("R10 set at end", v, 16'h0080);
    rstrt = 1; @(negedge clk); rstrt = 0;
    check("R11 restart after", {15'b0, tx_en}, 16'h1);
    wr_reg(0, 16'h0080);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_set_sticky();
        t_w1c();
        t_mask_irq();
        t_reserved();
        t_set_wins();
        t_gstop_idle();
        t_gstop_busy();
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule